// File: doc/BRIEF.md
# Folded Symmetric 8-Tap FIR Cell

This block is a streaming FIR filter for even-length coefficient sets whose taps mirror around the centre. It accepts one two's-complement sample per clock whenever the input valid is high, and keeps the most recent eight accepted samples in a window. Coefficient k is shared by two samples: the one k steps back from the newest and the one k steps forward from the oldest. The cell adds each such pair first and then multiplies. Eight taps therefore cost four multipliers, and only four coefficients are stored.

The four folded products are summed into a single full-precision result, one per accepted sample, once the window holds eight samples. A result register sits after the adder tree. Each sample carries an accumulate flag down the pipeline. When the flag is low, the result holds that sample's filter sum only. When the flag is high, the new sum is added to the previous result. Coefficients are loaded through a plain indexed write port. Reset is asynchronous and active low, and it is released to the internal logic through a two-stage synchroniser.

Top module: `symfir_fold8`

## Requirements
- R1: While reset is applied and after it is released, `res_valid` is 0 and `res_data` is 0 until the first result is produced.
- R2: Take w0 as the newest accepted sample and w7 as the oldest. A result equals (w0+w7)·C0 + (w1+w6)·C1 + (w2+w5)·C2 + (w3+w4)·C3. Samples and coefficients are signed two's complement.
- R3: `res_valid` is high for exactly one cycle, three clock edges after the edge that accepts a sample. This happens only if that sample is the eighth or a later accepted sample since reset. The first seven samples produce no result.
- R4: A clock edge where `smp_valid` is low shifts no sample into the window and produces no result. `res_data` keeps its value during every cycle where `res_valid` is low.
- R5: A write with `cf_we` high stores `cf_data` into coefficient Ck at the edge, where k is the value of `cf_idx` (0 to 3).
- R6: The accumulate flag is sampled together with each accepted sample. If the flag is 0, the result is that sample's sum alone. If it is 1, the result is the previous `res_data` plus the sum, wrapping modulo 2^27.
- R7: Full precision is kept for all input values. For example, all samples at -512 with all coefficients at -512 give 2097152, and all samples at -512 with all coefficients at 511 give -2093056.
- R8: Idle cycles between accepted samples do not change the result. The window advances only with accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 10 | Signed input sample |
| smp_accum | input | 1 | Accumulate flag travelling with the sample |
| cf_we | input | 1 | Coefficient write strobe |
| cf_idx | input | 2 | Coefficient index 0..3 |
| cf_data | input | 10 | Signed coefficient value |
| res_valid | output | 1 | Result qualifier |
| res_data | output | 27 | Signed full-precision result |

## Verification
The bench builds the cell with its default values: 10-bit samples, 10-bit coefficients, eight taps and four guard bits, which gives a 27-bit result. With these widths the extreme sample and coefficient values reach the full 23-bit folded sum. A run of forty accumulated extreme sums is short enough to drive the 27-bit result through a wrap. Streams with irregular gaps and single-coefficient sets check the pairing of samples and the coefficient indexing.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
  parameter int unsigned SF_DATA_W    = 10;
  parameter int unsigned SF_COEF_W    = 10;
  parameter int unsigned SF_TAPS      = 8;
  parameter int unsigned SF_ACC_GUARD = 4;

  // Per-sample control that travels beside the data path.
  typedef struct packed {
    logic vld;
    logic acc;
  } sf_tag_t;

  function automatic int unsigned sf_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/symfir_coef_bank.sv
module symfir_coef_bank
  import symfir_pkg::*;
#(
  parameter int unsigned HALF   = 4,
  parameter int unsigned COEF_W = 10,
  localparam int unsigned IDX_W = sf_idx_w(HALF)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [COEF_W-1:0]             wr_val,
  output logic [HALF-1:0][COEF_W-1:0]   coef_o
);
  logic [HALF-1:0][COEF_W-1:0] bank_q;
  logic [HALF-1:0][COEF_W-1:0] bank_d;
  logic [HALF-1:0]             sel;

  for (genvar k = 0; k < HALF; k++) begin : g_entry
    always_comb begin
      sel[k]    = wr_en && (wr_idx == IDX_W'(k));
      bank_d[k] = sel[k] ? wr_val : bank_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[k] <= '0;
      else        bank_q[k] <= bank_d[k];
    end
  end

  assign coef_o = bank_q;

  // R5: a write lands in the addressed entry
  a_r5_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bank_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/symfir_window.sv
module symfir_window
  import symfir_pkg::*;
#(
  parameter int unsigned TAPS   = 8,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned FILL_W = $clog2(TAPS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_vld,
  input  logic [DATA_W-1:0]             smp,
  input  logic                          acc_in,
  output logic [TAPS-1:0][DATA_W-1:0]   win_o,
  output sf_tag_t                       tag_o
);
  logic [TAPS-1:0][DATA_W-1:0] win_q, win_d;
  logic [FILL_W-1:0]           fill_q, fill_d;
  sf_tag_t                     tag_q, tag_d;
  logic                        full_now;

  always_comb begin
    full_now  = (fill_q >= FILL_W'(TAPS - 1));
    win_d     = smp_vld ? {win_q[TAPS-2:0], smp} : win_q;
    fill_d    = (smp_vld && (fill_q != FILL_W'(TAPS))) ? fill_q + 1'b1 : fill_q;
    tag_d.vld = smp_vld && full_now;
    tag_d.acc = smp_vld && acc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      tag_q  <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
      tag_q  <= tag_d;
    end
  end

  assign win_o = win_q;
  assign tag_o = tag_q;

  // R8: an accepted sample becomes the newest window entry
  a_r8_newest: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> win_q[0] == $past(smp));
  // R4: idle cycles leave the window untouched
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(win_q));
  // R3: a window is released only when it is full
  a_r3_full: assert property (@(posedge clk) disable iff (!rst_n)
    tag_q.vld |-> fill_q == FILL_W'(TAPS));
endmodule

// File: rtl/symfir_fold_mac.sv
module symfir_fold_mac
  import symfir_pkg::*;
#(
  parameter int unsigned TAPS   = 8,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned GUARD  = 4,
  localparam int unsigned HALF   = TAPS / 2,
  localparam int unsigned PRE_W  = DATA_W + 1,
  localparam int unsigned PROD_W = PRE_W + COEF_W,
  localparam int unsigned SUM_W  = PROD_W + sf_idx_w(HALF),
  localparam int unsigned OUT_W  = SUM_W + GUARD
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TAPS-1:0][DATA_W-1:0]   win,
  input  sf_tag_t                       tag_in,
  input  logic [HALF-1:0][COEF_W-1:0]   coef,
  output logic                          res_vld,
  output logic signed [OUT_W-1:0]       res
);
  logic signed [PRE_W-1:0]  pre_d  [HALF];
  logic signed [PRE_W-1:0]  pre_q  [HALF];
  logic signed [PROD_W-1:0] prod_d [HALF];
  logic signed [PROD_W-1:0] prod_q [HALF];
  logic signed [SUM_W-1:0]  sum_d;
  logic signed [OUT_W-1:0]  res_q, res_d;
  sf_tag_t                  tag1_q, tag2_q;
  logic                     vld_q;

  // Stage 1: fold mirrored samples; stage 2: multiply each fold
  for (genvar k = 0; k < HALF; k++) begin : g_fold
    always_comb begin
      pre_d[k]  = PRE_W'($signed(win[k])) + PRE_W'($signed(win[TAPS-1-k]));
      prod_d[k] = pre_q[k] * $signed(coef[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q[k]  <= '0;
        prod_q[k] <= '0;
      end else begin
        if (tag_in.vld) pre_q[k]  <= pre_d[k];
        if (tag1_q.vld) prod_q[k] <= prod_d[k];
      end
    end
  end

  // Stage 3: adder tree and optional accumulation
  always_comb begin
    sum_d = '0;
    for (int k = 0; k < HALF; k++) sum_d = sum_d + SUM_W'(prod_q[k]);
    res_d = tag2_q.acc ? res_q + OUT_W'(sum_d) : OUT_W'(sum_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1_q <= '0;
      tag2_q <= '0;
      vld_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      tag1_q <= tag_in;
      tag2_q <= tag1_q;
      vld_q  <= tag2_q.vld;
      if (tag2_q.vld) res_q <= res_d;
    end
  end

  assign res_vld = vld_q;
  assign res     = res_q;

  // R6: without the flag the result is one sample's sum only
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tag2_q.vld && !tag2_q.acc) |=> res_q == OUT_W'($past(sum_d)));
  // R6: with the flag the sum adds onto the previous result
  a_r6_accum: assert property (@(posedge clk) disable iff (!rst_n)
    (tag2_q.vld && tag2_q.acc) |=> res_q == $past(res_q) + OUT_W'($past(sum_d)));
  // R4: the result holds whenever no new result is due
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tag2_q.vld |=> $stable(res_q));
  // R3: fixed three-stage latency from released window
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(tag_in.vld, 3));
endmodule

// File: rtl/symfir_fold8.sv
module symfir_fold8
  import symfir_pkg::*;
#(
  parameter int unsigned DATA_W = SF_DATA_W,
  parameter int unsigned COEF_W = SF_COEF_W,
  parameter int unsigned TAPS   = SF_TAPS,
  parameter int unsigned GUARD  = SF_ACC_GUARD,
  localparam int unsigned HALF  = TAPS / 2,
  localparam int unsigned IDX_W = sf_idx_w(HALF),
  localparam int unsigned OUT_W = DATA_W + 1 + COEF_W + sf_idx_w(HALF) + GUARD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [DATA_W-1:0]        smp_data,
  input  logic                     smp_accum,
  input  logic                     cf_we,
  input  logic [IDX_W-1:0]         cf_idx,
  input  logic [COEF_W-1:0]        cf_data,
  output logic                     res_valid,
  output logic signed [OUT_W-1:0]  res_data
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [HALF-1:0][COEF_W-1:0]  coef;
  logic [TAPS-1:0][DATA_W-1:0]  win;
  sf_tag_t                      win_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  symfir_coef_bank #(.HALF(HALF), .COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cf_we), .wr_idx(cf_idx),
    .wr_val(cf_data), .coef_o(coef)
  );

  symfir_window #(.TAPS(TAPS), .DATA_W(DATA_W)) u_win (
    .clk(clk), .rst_n(rst_int_n), .smp_vld(smp_valid), .smp(smp_data),
    .acc_in(smp_accum), .win_o(win), .tag_o(win_tag)
  );

  symfir_fold_mac #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .GUARD(GUARD)) u_mac (
    .clk(clk), .rst_n(rst_int_n), .win(win), .tag_in(win_tag), .coef(coef),
    .res_vld(res_valid), .res(res_data)
  );

  // R1: nothing is reported while the core is held in reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!res_valid && res_data == '0));
endmodule

// File: tb/symfir_fold8_test.sv
module symfir_fold8_test;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_valid, smp_accum, cf_we;
  logic [9:0]        smp_data, cf_data;
  logic [1:0]        cf_idx;
  logic              res_valid;
  logic signed [26:0] res_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_en = 0;

  int mw[8];
  int mc[4];
  int filled = 0;
  logic signed [26:0] acc_model = '0;
  logic signed [26:0] last_res  = '0;
  logic signed [26:0] exp_q[$];
  string              tag_q[$];
  int                 cyc_q[$];

  symfir_fold8 uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_accum(smp_accum), .cf_we(cf_we), .cf_idx(cf_idx), .cf_data(cf_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int s, input bit acc, input string tag);
    int sum;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 10'(s); smp_accum = acc;
    for (int k = 7; k > 0; k--) mw[k] = mw[k-1];
    mw[0] = s;
    if (filled < 8) filled++;
    if (filled == 8) begin
      sum = 0;
      for (int k = 0; k < 4; k++) sum += (mw[k] + mw[7-k]) * mc[k];
      acc_model = acc ? acc_model + 27'(sum) : 27'(sum);
      exp_q.push_back(acc_model);
      tag_q.push_back(tag);
      cyc_q.push_back(cyc + 4);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0; smp_accum = 1'b0;
    end
  endtask

  task automatic wcoef(input int idx, input int v);
    @(negedge clk);
    smp_valid = 1'b0;
    cf_we = 1'b1; cf_idx = 2'(idx); cf_data = 10'(v);
    mc[idx] = v;
    @(negedge clk);
    cf_we = 1'b0;
  endtask

  // Monitor: compare results against the scoreboard
  always begin
    @(posedge clk);
    #5;
    if (mon_en) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected result", res_data, 0);
        end else begin
          automatic logic signed [26:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          automatic int ec = cyc_q.pop_front();
          check(res_data === e, t, res_data, e);
          check(cyc == ec, "R3 latency", cyc, ec);
        end
        last_res = res_data;
      end else begin
        check(res_data === last_res, "R4 hold while idle", res_data, last_res);
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) mw[k] = 0;
    for (int k = 0; k < 4; k++) mc[k] = 0;
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; smp_accum = 1'b0;
    cf_we = 1'b0; cf_idx = '0; cf_data = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    check(res_data == 0, "R1 data in reset", res_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_valid == 1'b0, "R1 valid after reset", res_valid, 0);
    check(res_data == 0, "R1 data after reset", res_data, 0);
    mon_en = 1;

    // R5 / R2: load asymmetric-valued folds and stream
    wcoef(0, 3); wcoef(1, -5); wcoef(2, 7); wcoef(3, -11);
    for (int i = 0; i < 20; i++) send(((i * 37 + 11) % 1024) - 512, 1'b0, "R2 stream");
    idle(6);

    // R8 / R4: irregular gaps between samples
    for (int i = 0; i < 16; i++) begin
      send(((i * 91 + 5) % 1024) - 512, 1'b0, "R8 gapped stream");
      idle(i % 4);
    end
    idle(6);

    // R5: one coefficient at a time exposes the pairing per index
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < 4; k++) wcoef(k, (k == j) ? 1 : 0);
      for (int i = 0; i < 9; i++) send(i * 13 - 60 + j, 1'b0, "R5 single coef");
      idle(6);
    end

    // R7: extremes
    for (int k = 0; k < 4; k++) wcoef(k, -512);
    for (int i = 0; i < 10; i++) send(-512, 1'b0, "R7 neg by neg");
    idle(6);
    check(last_res == 27'sd2097152, "R7 max positive", last_res, 2097152);
    for (int k = 0; k < 4; k++) wcoef(k, 511);
    for (int i = 0; i < 2; i++) send(-512, 1'b0, "R7 neg by pos");
    idle(6);
    check(last_res == -27'sd2093056, "R7 max negative", last_res, -2093056);

    // R6: long accumulation wraps, then a plain sample restarts
    for (int k = 0; k < 4; k++) wcoef(k, -512);
    send(-512, 1'b0, "R6 seed");
    for (int i = 0; i < 40; i++) send(-512, 1'b1, "R6 accumulate wrap");
    send(-512, 1'b0, "R6 accumulate off");
    idle(6);
    check(last_res == 27'sd2097152, "R6 restart after accumulate", last_res, 2097152);

    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule